// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Pair

This block performs 32x32 multiplication and 32/32 division, signed or unsigned, one bit per clock. A caller pulses `start` with an operation code and two operands. The unit then raises `busy` while it iterates. When it finishes, it writes the result into a dedicated pair of result registers. The high register takes the upper half of a product or the remainder of a division. The low register takes the lower half of a product or the quotient.

Neither operation names a destination. Software reads the two registers through the always-visible `hi_out` and `lo_out` ports, and the surrounding pipeline holds such reads back while `busy` is high. Two write strobes load either register directly from `wr_data`, so the pair can be saved and restored.

Multiplication is shift-and-add on operand magnitudes. Division is restoring division on magnitudes. Signs are applied in the same edge that writes the pair.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `hi_out` and `lo_out` are zero and `busy` is low.
- R2: Operation code 2'b00 multiplies the operands as two's-complement numbers. The 64-bit signed product has its upper half in HI and its lower half in LO.
- R3: Operation code 2'b01 multiplies the operands as unsigned numbers. The 64-bit product is split into HI and LO in the same way as for R2.
- R4: Operation code 2'b10 divides signed operands. LO gets the quotient, truncated toward zero. HI gets the remainder, which carries the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R5: Operation code 2'b11 divides unsigned operands. LO gets the quotient and HI gets the remainder.
- R6: A divisor of zero, for either divide code, completes normally with LO = 0xFFFFFFFF and HI equal to the dividend.
- R7: `start` is accepted only while `busy` is low. `busy` rises at the next edge and stays high for exactly 32 cycles. It falls at the same edge that writes HI and LO.
- R8: While `busy` is high, `hi_out` and `lo_out` keep the values they had before the operation. No partial result is ever visible on them.
- R9: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own operands and operation code.
- R10: While idle, `wr_hi` or `wr_lo` loads `wr_data` into HI or LO at the next edge. The other register is unchanged, and both may be written in the same cycle.
- R11: `wr_hi` and `wr_lo` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts an operation when idle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Load `wr_data` into HI |
| wr_lo | input | 1 | Load `wr_data` into LO |
| wr_data | input | 32 | Data for the move-to writes |
| busy | output | 1 | Operation in progress |
| hi_out | output | 32 | Current HI contents |
| lo_out | output | 32 | Current LO contents |

## Verification
Multiplication is tried with zero, all-ones and the most negative value under both signednesses, which separates sign-extension errors from magnitude errors. Division is driven with dividends of every sign combination against positive and negative divisors, which exposes quotient or remainder sign mistakes. It is also driven with a divisor larger than the dividend, a zero divisor, and the overflowing most-negative-by-minus-one case. Random operands from a fixed seed cover the bulk of the carry and borrow paths. On some of these runs, a second `start` and both move-to strobes are injected mid-operation to show that the running result is not disturbed.

// File: rtl/muldiv_pkg.sv
// Shared definitions for the multiply/divide unit.
// Assumes: the operation code is two bits; bit 1 selects divide, bit 0 selects unsigned.
package muldiv_pkg;
    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_MULU = 2'b01,
        OP_DIV  = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;
endpackage

// File: rtl/mul_core.sv
// Shift-and-add multiplier on unsigned magnitudes, one multiplier bit per step.
// Assumes: load and step are never high together; the caller counts WIDTH steps.
// prod_next is the product value after the current step (valid on the last one).
module mul_core #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod_next
);
    localparam int ACC_W = 2 * WIDTH + 1;

    logic [ACC_W-1:0] acc_q;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH:0]   partial;
    logic [ACC_W-1:0] shifted;

    // Add the multiplicand when the low multiplier bit is set, then shift right.
    always_comb begin
        partial   = acc_q[ACC_W-1:WIDTH] + (acc_q[0] ? {1'b0, mcand_q} : '0);
        shifted   = {1'b0, partial, acc_q[WIDTH-1:1]};
        prod_next = shifted[2*WIDTH-1:0];
    end

    // Accumulator and multiplicand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= {{(WIDTH+1){1'b0}}, mplier_in};
            mcand_q <= mcand_in;
        end else if (step) begin
            acc_q   <= shifted;
        end
    end
endmodule

// File: rtl/div_core.sv
// Restoring divider on unsigned magnitudes, one quotient bit per step.
// Assumes: load and step are never high together; the caller counts WIDTH steps.
// A zero divisor yields an all-ones quotient and a remainder equal to the dividend.
module div_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] dvd_in,
    input  logic [WIDTH-1:0] dvs_in,
    output logic [WIDTH-1:0] rem_next,
    output logic [WIDTH-1:0] quo_next
);
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH:0]   trial;
    logic [WIDTH:0]   diff;
    logic             fits;

    // Shift in the next dividend bit, subtract the divisor when it fits.
    always_comb begin
        trial    = {rem_q, quo_q[WIDTH-1]};
        diff     = trial - {1'b0, dvs_q};
        fits     = (trial >= {1'b0, dvs_q});
        rem_next = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
        quo_next = {quo_q[WIDTH-2:0], fits};
    end

    // Partial remainder, quotient/dividend shift register and divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dvd_in;
            dvs_q <= dvs_in;
        end else if (step) begin
            rem_q <= rem_next;
            quo_q <= quo_next;
        end
    end
endmodule

// File: rtl/hilo_muldiv_unit.sv
// Iterative multiply/divide unit owning the HI/LO result pair.
// Assumes: the caller holds off reads of hi_out/lo_out while busy is high;
// start and move-to writes arriving while busy are dropped.
module hilo_muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [WIDTH-1:0] wr_data,
    output logic             busy,
    output logic [WIDTH-1:0] hi_out,
    output logic [WIDTH-1:0] lo_out
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    logic               busy_q;
    logic [CNT_W-1:0]   cnt_q;
    md_op_e             op_q;
    logic               prod_neg_q, quo_neg_q, rem_neg_q;
    logic [WIDTH-1:0]   hi_q, lo_q;

    logic               go, last, signed_op, a_neg, b_neg;
    logic [WIDTH-1:0]   a_mag, b_mag;
    logic [2*WIDTH-1:0] prod_next, prod_fix;
    logic [WIDTH-1:0]   rem_next, quo_next, rem_fix, quo_fix;

    // Accept a new operation and strip operand signs.
    always_comb begin
        go        = start && !busy_q;
        signed_op = !op[0];
        a_neg     = signed_op && src_a[WIDTH-1];
        b_neg     = signed_op && src_b[WIDTH-1];
        a_mag     = a_neg ? -src_a : src_a;
        b_mag     = b_neg ? -src_b : src_b;
        last      = busy_q && (cnt_q == LAST_CNT);
    end

    mul_core #(.WIDTH(WIDTH)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .step      (busy_q && !op_q[1]),
        .mcand_in  (a_mag),
        .mplier_in (b_mag),
        .prod_next (prod_next)
    );

    div_core #(.WIDTH(WIDTH)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .step     (busy_q && op_q[1]),
        .dvd_in   (a_mag),
        .dvs_in   (b_mag),
        .rem_next (rem_next),
        .quo_next (quo_next)
    );

    // Re-apply signs to the final step's magnitudes.
    always_comb begin
        prod_fix = prod_neg_q ? -prod_next : prod_next;
        quo_fix  = quo_neg_q  ? -quo_next  : quo_next;
        rem_fix  = rem_neg_q  ? -rem_next  : rem_next;
    end

    // Sequencer: busy flag, step counter and latched sign flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            op_q       <= OP_MUL;
            prod_neg_q <= 1'b0;
            quo_neg_q  <= 1'b0;
            rem_neg_q  <= 1'b0;
        end else if (go) begin
            busy_q     <= 1'b1;
            cnt_q      <= '0;
            op_q       <= md_op_e'(op);
            prod_neg_q <= a_neg ^ b_neg;
            quo_neg_q  <= (a_neg ^ b_neg) && (src_b != '0);
            rem_neg_q  <= a_neg;
        end else if (busy_q) begin
            cnt_q      <= cnt_q + 1'b1;
            if (last) busy_q <= 1'b0;
        end
    end

    // HI/LO: final result write-back, or move-to writes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (last) begin
            hi_q <= op_q[1] ? rem_fix : prod_fix[2*WIDTH-1:WIDTH];
            lo_q <= op_q[1] ? quo_fix : prod_fix[WIDTH-1:0];
        end else if (!busy_q) begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) lo_q <= wr_data;
        end
    end

    assign busy   = busy_q;
    assign hi_out = hi_q;
    assign lo_out = lo_q;
endmodule

// File: rtl/hilo_muldiv_checker.sv
// Property checker for hilo_muldiv_unit, attached by bind.
// Assumes: only port-level signals are observed; busy length is counted here.
module hilo_muldiv_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             wr_hi,
    input logic             wr_lo,
    input logic [WIDTH-1:0] wr_data,
    input logic             busy,
    input logic [WIDTH-1:0] hi_out,
    input logic [WIDTH-1:0] lo_out
);
    localparam int BC_W = $clog2(WIDTH + 1) + 1;
    logic [BC_W-1:0] bcnt_q;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt_q <= '0;
        else                 bcnt_q <= bcnt_q + 1'b1;
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R7
    AST_BUSY_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt_q == BC_W'(WIDTH))); // R7
    AST_BUSY_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_q <= BC_W'(WIDTH)); // R7
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(hi_out) && $stable(lo_out)))); // R8
    AST_MOVE_DROPPED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (wr_hi || wr_lo)) |=> (!busy || ($stable(hi_out) && $stable(lo_out)))); // R11
    AST_MOVE_TO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_hi) |=> (hi_out == $past(wr_data))); // R10
    AST_MOVE_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_lo) |=> (lo_out == $past(wr_data))); // R10
    AST_IDLE_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_hi) |=> $stable(hi_out)); // R10
endmodule

bind hilo_muldiv_unit hilo_muldiv_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .busy    (busy),
    .hi_out  (hi_out),
    .lo_out  (lo_out)
);

// File: tb/hilo_muldiv_unit_bench.sv
// Self-checking bench: directed corner cases plus seeded random operations.
module hilo_muldiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] src_a = '0, src_b = '0, wr_data = '0;
    logic        wr_hi = 1'b0, wr_lo = 1'b0;
    logic        busy;
    logic [31:0] hi_out, lo_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] cur_hi = '0, cur_lo = '0;

    always #5 clk = ~clk;

    hilo_muldiv_unit u_hilo_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .busy(busy), .hi_out(hi_out), .lo_out(lo_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference result {HI, LO} computed from the requirements.
    function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] u;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (o)
            2'b00: begin q = sa * sb; return q; end
            2'b01: begin u = {32'b0, a} * {32'b0, b}; return u; end
            2'b10: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                q = sa / sb;
                r = sa % sb;
                return {r[31:0], q[31:0]};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic [31:0] b);
        if (o[1] && b == 0) return "R6";
        case (o)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Run one operation; optionally inject start and move-to writes mid-run.
    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input bit disturb);
        logic [63:0] exp;
        int k;
        exp = model(o, a, b);
        @(negedge clk);
        start = 1'b1; op = o; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0; src_a = $urandom; src_b = $urandom;
        check("R7 busy after start", {31'b0, busy}, 32'd1);
        k = 0;
        if (disturb) begin
            start = 1'b1; op = ~o; wr_hi = 1'b1; wr_lo = 1'b1; wr_data = $urandom;
            @(negedge clk);
            start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
            k = 1;
        end
        repeat (31 - k) @(negedge clk);
        check("R7 busy on 32nd cycle", {31'b0, busy}, 32'd1);
        check("R8 HI held while busy", hi_out, cur_hi);
        check("R8 LO held while busy", lo_out, cur_lo);
        @(negedge clk);
        check("R7 busy cleared", {31'b0, busy}, 32'd0);
        if (disturb) begin
            check("R9 R11 HI after disturbed run", hi_out, exp[63:32]);
            check("R9 R11 LO after disturbed run", lo_out, exp[31:0]);
        end else begin
            check({tag_of(o, b), " HI"}, hi_out, exp[63:32]);
            check({tag_of(o, b), " LO"}, lo_out, exp[31:0]);
        end
        cur_hi = hi_out;
        cur_lo = lo_out;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 6)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return $urandom % 16;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 HI reset", hi_out, 32'd0);
        check("R1 LO reset", lo_out, 32'd0);
        check("R1 busy reset", {31'b0, busy}, 32'd0);

        // R10: move-to writes while idle
        wr_hi = 1'b1; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        wr_hi = 1'b0;
        check("R10 HI written", hi_out, 32'hDEAD_BEEF);
        check("R10 LO untouched", lo_out, 32'd0);
        wr_lo = 1'b1; wr_data = 32'h1234_5678;
        @(negedge clk);
        wr_lo = 1'b0;
        check("R10 LO written", lo_out, 32'h1234_5678);
        check("R10 HI untouched", hi_out, 32'hDEAD_BEEF);
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h0BAD_F00D;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        check("R10 both HI", hi_out, 32'h0BAD_F00D);
        check("R10 both LO", lo_out, 32'h0BAD_F00D);
        cur_hi = hi_out; cur_lo = lo_out;

        // Directed corners
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0); // R2 -1*-1
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0); // R2 min*min
        run_op(2'b00, 32'hFFFF_FFF9, 32'd6, 0);         // R2 neg*pos
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0); // R3 max*max
        run_op(2'b01, 32'd0, 32'hABCD_0123, 0);         // R3 zero
        run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0);         // R4 -7/2
        run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0);         // R4 7/-2
        run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0); // R4 -7/-2
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0); // R4 overflow case
        run_op(2'b11, 32'd5, 32'd9, 0);                 // R5 divisor larger
        run_op(2'b11, 32'hFFFF_FFFF, 32'd10, 0);        // R5
        run_op(2'b11, 32'h1234_5678, 32'd0, 0);         // R6 unsigned
        run_op(2'b10, 32'hFFFF_FF00, 32'd0, 0);         // R6 signed negative dividend
        run_op(2'b00, 32'd12345, 32'hFFFF_0000, 1);     // R9 R11 disturbed
        run_op(2'b10, 32'hF000_0001, 32'd3, 1);         // R9 R11 disturbed

        // Seeded random operations
        for (int i = 0; i < 48; i++) begin
            run_op(2'($urandom % 4), pick(), pick(), (i % 4) == 3);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule